// File: doc/BRIEF.md
# I2C Queue Threshold and Interrupt Status Unit

This unit sits beside the command queue and the receive queue of an I2C master controller. It compares the fill level of each queue with a threshold picked by a 2-bit code and turns each comparison into a "ready" condition. It also keeps three sticky error conditions, which the bus engine raises with one-cycle event pulses: the target did not acknowledge, arbitration was lost, and a byte arrived while the receive queue was full. All five conditions appear in a raw status vector. The same vector ANDed with an interrupt enable vector gives a masked status, and the OR of the masked bits drives one interrupt line.

Software-style control reaches the unit through plain strobe-plus-mask pins. One pair sets enable bits and one pair clears them. A third pair performs write-one-to-clear on the status. A controller-enable level input removes the command-queue interrupt enable whenever the controller is off. The unit also tells the receive path whether an arriving byte may be stored. A byte offered while the queue is full is still taken on the bus, but it is dropped and the overflow condition is recorded.

All pins are plain control and status signals. No valid/ready handshake exists, and no back-pressure is applied to the bus engine. Every status and enable bit is registered, so a change at the inputs shows at the outputs after the next rising clock edge. The masked status and the interrupt line follow those registers without further delay.

Top module: `qlvl_irq_unit`

## Requirements
- R1: While reset is asserted, `raw_status`, `ien_o` and `masked_status` are all zero and `irq` is low.
- R2: Status bit 0 (command room) is 1 one cycle after `cmd_level` is at or below the command threshold. `cmd_thr_code` selects the threshold: 0 means 0 entries, 1 means DEPTH/4, 2 means DEPTH/2 and 3 means DEPTH-1 (at least one free entry).
- R3: Status bit 1 (receive data available) is 1 one cycle after `rx_level` is at or above the receive threshold. `rx_thr_code` selects the threshold: 0 means 1 entry, 1 means DEPTH/4, 2 means DEPTH/2 and 3 means DEPTH. The bit returns to 0 by itself once the level falls below the threshold.
- R4: A pulse on `ev_nack` sets status bit 2 and a pulse on `ev_arb_lost` sets status bit 3, one cycle later. Each bit stays set until it is cleared explicitly.
- R5: A cycle with `stat_clr_valid` high clears each sticky bit (2, 3, 4) whose `stat_clr_mask` bit is 1. A sticky bit whose mask bit is 0 is left as it is. An event in the same cycle wins over the clear. Mask bits 0 and 1 have no effect.
- R6: When `rx_push` is high and `rx_level` equals DEPTH, `rx_store_o` is low and status bit 4 (overflow) is set one cycle later. When `rx_push` is high below full, `rx_store_o` is high and bit 4 is not set.
- R7: `raw_status` does not depend on the enable vector. `masked_status` equals `raw_status` AND `ien_o`.
- R8: `irq` is high exactly when at least one bit of `masked_status` is 1.
- R9: `ien_set_valid` sets the enable bits that are 1 in `ien_set_mask`, and `ien_clr_valid` clears the enable bits that are 1 in `ien_clr_mask`. The change is visible one cycle later. Bits that are 0 in a mask are kept. When the same bit is both set and cleared in one cycle, the clear wins.
- R10: While `ctrl_enable` is low, enable bit 0 is cleared and cannot be set. The other enable bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_enable | input | 1 | Controller enabled level |
| cmd_level | input | LVLW | Command queue fill level (0..DEPTH) |
| rx_level | input | LVLW | Receive queue fill level (0..DEPTH) |
| cmd_thr_code | input | 2 | Command threshold code |
| rx_thr_code | input | 2 | Receive threshold code |
| ev_nack | input | 1 | Pulse: target did not acknowledge |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| rx_push | input | 1 | Pulse: received byte offered to the receive queue |
| ien_set_valid | input | 1 | Strobe for enable set |
| ien_set_mask | input | 5 | Enable bits to set |
| ien_clr_valid | input | 1 | Strobe for enable clear |
| ien_clr_mask | input | 5 | Enable bits to clear |
| stat_clr_valid | input | 1 | Strobe for write-one-to-clear of status |
| stat_clr_mask | input | 5 | Status bits to clear |
| rx_store_o | output | 1 | Offered byte may be written into the receive queue |
| raw_status | output | 5 | Unmasked status vector |
| masked_status | output | 5 | Status ANDed with enables |
| ien_o | output | 5 | Current interrupt enable vector |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives each queue level to exactly one step on either side of each of the four thresholds. A wrong quarter or half computation, or a strict comparison where an inclusive one is needed, therefore flips a ready bit at one boundary level. It clears one sticky bit while another is set, to catch a design that clears the whole vector. It also raises an event in the same cycle as its clear, to catch a design that lets the clear win. A push into a full queue must drop the store strobe and set overflow, while a push below full must not. Finally, the bench checks that an enable set collides with its clear in favour of the clear, and that a set of enable bit 0 while the controller is off has no effect, which catches an enable register that ignores the off state.

// File: rtl/qlvl_pkg.sv
package qlvl_pkg;
  localparam int NSTAT    = 5;
  localparam int BIT_CMD  = 0;
  localparam int BIT_RXA  = 1;
  localparam int BIT_NACK = 2;
  localparam int BIT_ARB  = 3;
  localparam int BIT_OVF  = 4;

  typedef logic [NSTAT-1:0] stat_t;

  // bits that hold until cleared; the rest follow a level each cycle
  localparam stat_t STICKY_MASK = 5'b11100;
endpackage

// File: rtl/qlvl_thresh.sv
module qlvl_thresh #(
  parameter int DEPTH = 16,
  parameter int LVLW  = $clog2(DEPTH + 1),
  parameter bit IS_RX = 1'b0
) (
  input  logic [LVLW-1:0] level,
  input  logic [1:0]      code,
  output logic            hit
);
  localparam int QTR  = DEPTH / 4;
  localparam int HALF = DEPTH / 2;

  logic [LVLW-1:0] thr;

  generate
    if (IS_RX) begin : g_rx
      // receive side: fill at or above threshold
      always_comb begin
        case (code)
          2'd0:    thr = LVLW'(1);
          2'd1:    thr = LVLW'(QTR);
          2'd2:    thr = LVLW'(HALF);
          default: thr = LVLW'(DEPTH);
        endcase
      end
      assign hit = (level >= thr);
    end else begin : g_cmd
      // command side: fill at or below threshold
      always_comb begin
        case (code)
          2'd0:    thr = '0;
          2'd1:    thr = LVLW'(QTR);
          2'd2:    thr = LVLW'(HALF);
          default: thr = LVLW'(DEPTH - 1);
        endcase
      end
      assign hit = (level <= thr);
    end
  endgenerate
endmodule

// File: rtl/qlvl_status_reg.sv
module qlvl_status_reg
  import qlvl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t src,   // level value or event pulse per bit
  input  stat_t clr,   // write-one-to-clear mask, already qualified
  output stat_t q
);
  generate
    for (genvar i = 0; i < NSTAT; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)
          q[i] <= 1'b0;
        else if (STICKY_MASK[i])
          q[i] <= (q[i] & ~clr[i]) | src[i];
        else
          q[i] <= src[i];
      end
    end
  endgenerate
endmodule

// File: rtl/qlvl_ien.sv
module qlvl_ien
  import qlvl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_enable,
  input  logic  set_valid,
  input  stat_t set_mask,
  input  logic  clr_valid,
  input  stat_t clr_mask,
  output stat_t ien
);
  stat_t set_eff, clr_eff, nxt;

  always_comb begin
    set_eff = set_valid ? set_mask : '0;
    clr_eff = clr_valid ? clr_mask : '0;
    nxt     = (ien | set_eff) & ~clr_eff;
    if (!ctrl_enable)
      nxt[BIT_CMD] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ien <= '0;
    else        ien <= nxt;
  end
endmodule

// File: rtl/qlvl_irq_unit.sv
module qlvl_irq_unit
  import qlvl_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_enable,
  input  logic [LVLW-1:0] cmd_level,
  input  logic [LVLW-1:0] rx_level,
  input  logic [1:0]      cmd_thr_code,
  input  logic [1:0]      rx_thr_code,
  input  logic            ev_nack,
  input  logic            ev_arb_lost,
  input  logic            rx_push,
  input  logic            ien_set_valid,
  input  logic [4:0]      ien_set_mask,
  input  logic            ien_clr_valid,
  input  logic [4:0]      ien_clr_mask,
  input  logic            stat_clr_valid,
  input  logic [4:0]      stat_clr_mask,
  output logic            rx_store_o,
  output logic [4:0]      raw_status,
  output logic [4:0]      masked_status,
  output logic [4:0]      ien_o,
  output logic            irq
);
  logic  cmd_hit, rx_hit, rx_full;
  stat_t src, clr_eff, raw_q, ien_q;

  qlvl_thresh #(.DEPTH(DEPTH), .LVLW(LVLW), .IS_RX(1'b0)) u_cmd_thr (
    .level(cmd_level), .code(cmd_thr_code), .hit(cmd_hit)
  );

  qlvl_thresh #(.DEPTH(DEPTH), .LVLW(LVLW), .IS_RX(1'b1)) u_rx_thr (
    .level(rx_level), .code(rx_thr_code), .hit(rx_hit)
  );

  assign rx_full    = (rx_level == LVLW'(DEPTH));
  assign rx_store_o = rx_push & ~rx_full;

  always_comb begin
    src           = '0;
    src[BIT_CMD]  = cmd_hit;
    src[BIT_RXA]  = rx_hit;
    src[BIT_NACK] = ev_nack;
    src[BIT_ARB]  = ev_arb_lost;
    src[BIT_OVF]  = rx_push & rx_full;
    clr_eff       = stat_clr_valid ? (stat_clr_mask & STICKY_MASK) : '0;
  end

  qlvl_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .src(src), .clr(clr_eff), .q(raw_q)
  );

  qlvl_ien u_ien (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable),
    .set_valid(ien_set_valid), .set_mask(ien_set_mask),
    .clr_valid(ien_clr_valid), .clr_mask(ien_clr_mask),
    .ien(ien_q)
  );

  assign raw_status    = raw_q;
  assign ien_o         = ien_q;
  assign masked_status = raw_q & ien_q;
  assign irq           = |masked_status;
endmodule

// File: rtl/qlvl_irq_unit_chk.sv
module qlvl_irq_unit_chk #(
  parameter int DEPTH = 16,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctrl_enable,
  input logic [LVLW-1:0] rx_level,
  input logic            ev_nack,
  input logic            ev_arb_lost,
  input logic            rx_push,
  input logic            ien_set_valid,
  input logic            ien_clr_valid,
  input logic            stat_clr_valid,
  input logic [4:0]      stat_clr_mask,
  input logic            rx_store_o,
  input logic [4:0]      raw_status,
  input logic [4:0]      masked_status,
  input logic [4:0]      ien_o,
  input logic            irq
);
  p_nack_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> raw_status[2]);

  p_arb_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> raw_status[3]);

  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[2] && !(stat_clr_valid && stat_clr_mask[2])) |=> raw_status[2]);

  p_ovf_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_level == LVLW'(DEPTH)) |-> (!rx_store_o ##1 raw_status[4]));

  p_mask_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((masked_status & ~raw_status) == 5'd0) && ((masked_status & ~ien_o) == 5'd0));

  p_irq_any_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_status & ien_o) != 5'd0) |-> irq);

  p_ien_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_set_valid && !ien_clr_valid && ctrl_enable) |=> $stable(ien_o));

  p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_enable |=> !ien_o[0]);
endmodule

bind qlvl_irq_unit qlvl_irq_unit_chk #(.DEPTH(DEPTH), .LVLW(LVLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .rx_level(rx_level),
  .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost), .rx_push(rx_push),
  .ien_set_valid(ien_set_valid), .ien_clr_valid(ien_clr_valid),
  .stat_clr_valid(stat_clr_valid), .stat_clr_mask(stat_clr_mask),
  .rx_store_o(rx_store_o), .raw_status(raw_status),
  .masked_status(masked_status), .ien_o(ien_o), .irq(irq)
);

// File: tb/sim_qlvl_irq_unit.sv
module sim_qlvl_irq_unit;
  localparam int DEPTH = 16;
  localparam int LVLW  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_enable = 1'b1;
  logic [LVLW-1:0] cmd_level = '0, rx_level = '0;
  logic [1:0] cmd_thr_code = '0, rx_thr_code = '0;
  logic ev_nack = 1'b0, ev_arb_lost = 1'b0, rx_push = 1'b0;
  logic ien_set_valid = 1'b0, ien_clr_valid = 1'b0, stat_clr_valid = 1'b0;
  logic [4:0] ien_set_mask = '0, ien_clr_mask = '0, stat_clr_mask = '0;
  logic rx_store_o, irq;
  logic [4:0] raw_status, masked_status, ien_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qlvl_irq_unit #(.DEPTH(DEPTH)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    tick();
    tick();
    chk("R1 raw in reset", 32'(raw_status), 0);
    chk("R1 ien in reset", 32'(ien_o), 0);
    chk("R1 irq in reset", 32'(irq), 0);
    rst_n = 1'b1;
  endtask

  task automatic cmd_case(input logic [1:0] code, input int lvl, input logic exp);
    cmd_thr_code = code;
    cmd_level = LVLW'(lvl);
    tick();
    chk($sformatf("R2 cmd code=%0d lvl=%0d", code, lvl), 32'(raw_status[0]), 32'(exp));
  endtask

  task automatic t_cmd_thr();
    cmd_case(2'd0, 0, 1'b1);  cmd_case(2'd0, 1, 1'b0);
    cmd_case(2'd1, 4, 1'b1);  cmd_case(2'd1, 5, 1'b0);
    cmd_case(2'd2, 8, 1'b1);  cmd_case(2'd2, 9, 1'b0);
    cmd_case(2'd3, 15, 1'b1); cmd_case(2'd3, 16, 1'b0);
  endtask

  task automatic rx_case(input logic [1:0] code, input int lvl, input logic exp);
    rx_thr_code = code;
    rx_level = LVLW'(lvl);
    tick();
    chk($sformatf("R3 rx code=%0d lvl=%0d", code, lvl), 32'(raw_status[1]), 32'(exp));
  endtask

  task automatic t_rx_thr();
    rx_case(2'd0, 0, 1'b0);  rx_case(2'd0, 1, 1'b1);
    rx_case(2'd1, 3, 1'b0);  rx_case(2'd1, 4, 1'b1);
    rx_case(2'd2, 7, 1'b0);  rx_case(2'd2, 8, 1'b1);
    rx_case(2'd3, 16, 1'b1); rx_case(2'd3, 15, 1'b0);
  endtask

  task automatic pulse_nack();
    ev_nack = 1'b1; tick(); ev_nack = 1'b0;
  endtask

  task automatic t_sticky();
    cmd_level = LVLW'(16); cmd_thr_code = 2'd0;
    rx_level = '0; rx_thr_code = 2'd0;
    tick();
    chk("R4 quiet base", 32'(raw_status), 0);
    pulse_nack();
    chk("R4 nack set", 32'(raw_status), 32'h04);
    tick(); tick(); tick();
    chk("R4 nack held", 32'(raw_status), 32'h04);
    ev_arb_lost = 1'b1; tick(); ev_arb_lost = 1'b0;
    chk("R4 arb set", 32'(raw_status), 32'h0C);
  endtask

  task automatic t_w1c();
    stat_clr_valid = 1'b1; stat_clr_mask = 5'b00100; tick(); stat_clr_valid = 1'b0;
    chk("R5 clear only nack", 32'(raw_status), 32'h08);
    stat_clr_valid = 1'b1; stat_clr_mask = 5'b01000; ev_arb_lost = 1'b1; tick();
    stat_clr_valid = 1'b0; ev_arb_lost = 1'b0;
    chk("R5 event beats clear", 32'(raw_status), 32'h08);
    stat_clr_valid = 1'b1; stat_clr_mask = 5'b11111; tick(); stat_clr_valid = 1'b0;
    chk("R5 clear all sticky", 32'(raw_status), 0);
    cmd_level = '0; tick();
    stat_clr_valid = 1'b1; stat_clr_mask = 5'b00011; tick(); stat_clr_valid = 1'b0;
    chk("R5 level bit not cleared", 32'(raw_status), 32'h01);
    cmd_level = LVLW'(16); tick();
  endtask

  task automatic t_ovf();
    rx_thr_code = 2'd3; rx_level = LVLW'(16); tick();
    rx_push = 1'b1; #1;
    chk("R6 store low when full", 32'(rx_store_o), 0);
    tick(); rx_push = 1'b0;
    chk("R6 overflow set", 32'(raw_status), 32'h12);
    stat_clr_valid = 1'b1; stat_clr_mask = 5'b10000; tick(); stat_clr_valid = 1'b0;
    chk("R6 overflow cleared", 32'(raw_status[4]), 0);
    rx_level = LVLW'(10); rx_push = 1'b1; #1;
    chk("R6 store high below full", 32'(rx_store_o), 1);
    tick(); rx_push = 1'b0;
    chk("R6 no overflow below full", 32'(raw_status), 0);
  endtask

  task automatic t_mask_irq();
    pulse_nack();
    chk("R7 raw shows nack while disabled", 32'(raw_status), 32'h04);
    chk("R7 masked empty", 32'(masked_status), 0);
    chk("R8 irq low", 32'(irq), 0);
    ien_set_valid = 1'b1; ien_set_mask = 5'b00110; tick(); ien_set_valid = 1'b0;
    chk("R7 masked nack only", 32'(masked_status), 32'h04);
    chk("R8 irq high", 32'(irq), 1);
    stat_clr_valid = 1'b1; stat_clr_mask = 5'b00100; tick(); stat_clr_valid = 1'b0;
    chk("R8 irq drops", 32'(irq), 0);
  endtask

  task automatic t_ien();
    ien_clr_valid = 1'b1; ien_clr_mask = 5'b11111; tick(); ien_clr_valid = 1'b0;
    ien_set_valid = 1'b1; ien_set_mask = 5'b00011; tick();
    ien_set_mask = 5'b00100; tick(); ien_set_valid = 1'b0;
    chk("R9 set accumulates", 32'(ien_o), 32'h07);
    ien_clr_valid = 1'b1; ien_clr_mask = 5'b00001; tick(); ien_clr_valid = 1'b0;
    chk("R9 clear one bit", 32'(ien_o), 32'h06);
    ien_set_valid = 1'b1; ien_set_mask = 5'b01000;
    ien_clr_valid = 1'b1; ien_clr_mask = 5'b01000; tick();
    ien_set_valid = 1'b0; ien_clr_valid = 1'b0;
    chk("R9 clear wins", 32'(ien_o), 32'h06);
  endtask

  task automatic t_disable();
    ien_set_valid = 1'b1; ien_set_mask = 5'b11111; tick(); ien_set_valid = 1'b0;
    chk("R10 all enabled", 32'(ien_o), 32'h1F);
    ctrl_enable = 1'b0; tick();
    chk("R10 bit0 cleared on disable", 32'(ien_o), 32'h1E);
    ien_set_valid = 1'b1; ien_set_mask = 5'b00001; tick(); ien_set_valid = 1'b0;
    chk("R10 bit0 set blocked", 32'(ien_o), 32'h1E);
    ctrl_enable = 1'b1;
    ien_set_valid = 1'b1; tick(); ien_set_valid = 1'b0;
    chk("R10 bit0 settable again", 32'(ien_o), 32'h1F);
  endtask

  initial begin
    #(1_000_000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_cmd_thr();
    t_rx_thr();
    t_sticky();
    t_w1c();
    t_ovf();
    t_mask_irq();
    t_ien();
    t_disable();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule